// File: doc/BRIEF.md
# Card reader pre-read feed controller

This block models the feed path of a punched-card reader whose cards pass through a pre-read station before they are read. It holds whole cards in a small ring of card slots. The host fills the hopper one 12-bit column at a time, and a card joins the hopper once all 80 of its columns have been written. A feed request from the CPU side starts one feed cycle. During that cycle the card waiting in pre-read goes to the read side and the next hopper card moves up into pre-read. A card is therefore read on the cycle after the one that fed it.

When the hopper runs dry, the last card stays parked in pre-read, and ordinary feed requests wait with a not-ready status bit raised. Three things release the parked card. Loading more cards resumes normal reading. An armed operator last-card request runs one cycle that reads the card and flags the status word. A non-process runout discards the card unread. Every state change happens inside the block within a fixed number of clocks, so the card rate is set only by the feed and column-pacing parameters.

Top module: `card_feed_ctrl`

## Requirements
- R1: A column is written on each clock where `ld_valid` and `ld_ready` are both high. Every 80 writes complete one card, which enters the hopper. `ld_ready` is low while all `CARD_SLOTS` slots hold complete cards. `hopper_empty` is high when no card waits in the hopper.
- R2: An accepted feed cycle moves the next hopper card into pre-read. If pre-read held a card, that card is read during the same cycle. A cycle that starts with pre-read empty reads nothing and produces no strobes.
- R3: A read delivers exactly 80 pulses on `col_strobe`, spaced `COL_GAP` clocks apart. `col_num` runs from 1 to 80, and `col_data` equals the value loaded for that column.
- R4: Status bit 0 (busy) is high for the whole feed cycle. That is `FEED_CYCLES` clocks for a cycle without a read, and `FEED_CYCLES + 80*COL_GAP + 2` clocks for a cycle with a read. `read_done` pulses for one clock, the clock after the last strobe, and busy is low on the clock after that.
- R5: A feed request made while the hopper is empty, with no last-card cycle possible, is held and nothing moves. While this holds, status bit 1 (not ready) is high. Loading a card starts the held cycle, which reads the parked card with status bit 2 left clear.
- R6: After `lc_req` is pulsed, with the hopper empty and a card parked, the next feed request runs one cycle that reads the parked card and sets status bit 2 (last card). The arming is used up by that cycle, so not-ready rises again afterwards.
- R7: Status bit 2 stays set until `stat_clr` is pulsed.
- R8: A `runout` pulse while idle discards the parked card without strobes. While pre-read is empty, a `runout` pulse has no effect.
- R9: `feed_req` and `runout` pulses that arrive during a feed cycle are ignored.
- R10: After reset the status word is 3'b010 (not ready only), the hopper is empty, `ld_ready` is high and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Host column write strobe |
| ld_data | input | 12 | Column punch pattern being loaded |
| ld_ready | output | 1 | A slot is free for loading |
| hopper_empty | output | 1 | No complete card waits in the hopper |
| feed_req | input | 1 | Feed-cycle request pulse from the CPU side |
| lc_req | input | 1 | Operator last-card request pulse |
| runout | input | 1 | Operator non-process runout pulse |
| stat_clr | input | 1 | CPU reset of the last-card status bit |
| col_strobe | output | 1 | One column is presented |
| col_data | output | 12 | Presented column pattern |
| col_num | output | 7 | Column number, 1 to 80 |
| read_done | output | 1 | Pulse after the final column of a card |
| dsw | output | 3 | Status: bit0 busy, bit1 not ready, bit2 last card |

## Verification
The bound checker enforces the relationships that hold on every clock. Strobes only occur while busy, and column numbers stay in range. A read-complete pulse follows directly after column 80 and is followed by busy falling. Not-ready implies an empty hopper, a full store implies a non-empty hopper, and the last-card bit is held until cleared. Only the bench scenarios can show the one-cycle lag between feed and read, the hold on an empty hopper and its release by loading or by the last-card cycle, and the discard by runout. The same applies to exact cycle lengths and to requests that are dropped during a cycle.

// File: rtl/card_feed_pkg.sv
package card_feed_pkg;

    localparam int COLS      = 80;
    localparam int COL_W     = 12;
    localparam int COL_IDX_W = $clog2(COLS + 1);

    typedef logic [COL_W-1:0] col_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_FEED,
        SQ_READ
    } seq_st_e;

    typedef struct packed {
        logic last_card;
        logic not_ready;
        logic busy;
    } dsw_t;

    function automatic logic is_final_col(input logic [COL_IDX_W-1:0] idx);
        return idx == COL_IDX_W'(COLS - 1);
    endfunction

endpackage

// File: rtl/card_feed_store.sv
module card_feed_store
    import card_feed_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  col_t                     wr_data,
    output logic                     card_done,
    input  logic [$clog2(SLOTS)-1:0] rd_slot,
    input  logic [COL_IDX_W-1:0]     rd_col,
    output col_t                     rd_data
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int DEPTH  = SLOTS * COLS;
    localparam int AW     = $clog2(DEPTH);

    col_t                 mem [DEPTH];
    logic [SLOT_W-1:0]    wr_slot;
    logic [COL_IDX_W-1:0] fill_col;
    logic [AW-1:0]        wr_addr;
    logic [AW-1:0]        rd_addr;

    always_comb begin
        wr_addr   = AW'(int'(wr_slot) * COLS + int'(fill_col));
        rd_addr   = AW'(int'(rd_slot) * COLS + int'(rd_col));
        card_done = wr_en && is_final_col(fill_col);
        rd_data   = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_slot  <= '0;
            fill_col <= '0;
        end else if (wr_en) begin
            if (is_final_col(fill_col)) begin
                fill_col <= '0;
                wr_slot  <= (wr_slot == SLOT_W'(SLOTS - 1)) ? '0 : wr_slot + 1'b1;
            end else begin
                fill_col <= fill_col + 1'b1;
            end
        end
    end

endmodule

// File: rtl/card_feed_seq.sv
module card_feed_seq
    import card_feed_pkg::*;
#(
    parameter int SLOTS       = 4,
    parameter int FEED_CYCLES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     feed_req,
    input  logic                     lc_req,
    input  logic                     runout,
    input  logic                     stat_clr,
    input  logic                     card_done,
    input  logic                     col_done,
    output logic                     col_start,
    output logic [$clog2(SLOTS)-1:0] rd_slot,
    output logic                     hopper_empty,
    output logic                     ld_ready,
    output dsw_t                     status
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam int CW     = $clog2(SLOTS + 1);
    localparam int FCW    = $clog2(FEED_CYCLES + 1);

    seq_st_e           st;
    logic [FCW-1:0]    fcnt;
    logic [CW-1:0]     hop_cnt;
    logic [SLOT_W-1:0] head;
    logic              pre_valid;
    logic              reading;
    logic              armed;
    logic              pend;
    logic              cyc_last;
    logic              last_bit;

    logic [CW:0]       occ;
    logic              can_normal;
    logic              can_last;
    logic              go;
    logic              feed_end;
    logic              ro_take;
    logic              last_set;

    function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] s);
        return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
    endfunction

    always_comb begin
        can_normal = (hop_cnt != '0);
        can_last   = armed && pre_valid;
        go         = (st == SQ_IDLE) && (feed_req || pend) && (can_normal || can_last);
        feed_end   = (st == SQ_FEED) && (fcnt == FCW'(FEED_CYCLES - 1));
        col_start  = feed_end && reading;
        ro_take    = (st == SQ_IDLE) && !go && runout && pre_valid;
        last_set   = (st == SQ_READ) && col_done && cyc_last;
        occ        = {1'b0, hop_cnt} + (CW+1)'(pre_valid) + (CW+1)'(reading);
        ld_ready   = occ < (CW+1)'(SLOTS);
        hopper_empty     = !can_normal;
        status.busy      = (st != SQ_IDLE);
        status.not_ready = !can_normal && !can_last;
        status.last_card = last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            fcnt      <= '0;
            hop_cnt   <= '0;
            head      <= '0;
            rd_slot   <= '0;
            pre_valid <= 1'b0;
            reading   <= 1'b0;
            armed     <= 1'b0;
            pend      <= 1'b0;
            cyc_last  <= 1'b0;
            last_bit  <= 1'b0;
        end else begin
            if (go) begin
                pend <= 1'b0;
            end else if ((st == SQ_IDLE) && feed_req) begin
                pend <= 1'b1;
            end
            hop_cnt  <= hop_cnt + CW'(card_done) - CW'(go && can_normal);
            armed    <= (armed && !(go && !can_normal)) || lc_req;
            last_bit <= last_set || (last_bit && !stat_clr);

            unique case (st)
                SQ_IDLE: begin
                    if (go) begin
                        st        <= SQ_FEED;
                        fcnt      <= '0;
                        cyc_last  <= !can_normal;
                        pre_valid <= can_normal;
                        if (pre_valid) begin
                            rd_slot <= head;
                            reading <= 1'b1;
                            head    <= nxt(head);
                        end
                    end else if (ro_take) begin
                        pre_valid <= 1'b0;
                        head      <= nxt(head);
                    end
                end
                SQ_FEED: begin
                    fcnt <= fcnt + 1'b1;
                    if (feed_end) begin
                        st <= reading ? SQ_READ : SQ_IDLE;
                    end
                end
                SQ_READ: begin
                    if (col_done) begin
                        st      <= SQ_IDLE;
                        reading <= 1'b0;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/card_feed_colout.sv
module card_feed_colout
    import card_feed_pkg::*;
#(
    parameter int COL_GAP = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  col_t                 rd_data,
    output logic [COL_IDX_W-1:0] rd_col,
    output logic                 col_strobe,
    output col_t                 col_data,
    output logic [COL_IDX_W-1:0] col_num,
    output logic                 done
);

    localparam int GW = $clog2(COL_GAP + 1);

    logic                 active;
    logic [GW-1:0]        timer;
    logic [COL_IDX_W-1:0] col;

    assign rd_col = col;

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            timer      <= '0;
            col        <= '0;
            col_strobe <= 1'b0;
            col_data   <= '0;
            col_num    <= '0;
            done       <= 1'b0;
        end else begin
            col_strobe <= 1'b0;
            done       <= col_strobe && (col_num == COL_IDX_W'(COLS));
            if (start) begin
                active <= 1'b1;
                timer  <= '0;
                col    <= '0;
            end else if (active) begin
                if (timer == GW'(COL_GAP - 1)) begin
                    timer      <= '0;
                    col_strobe <= 1'b1;
                    col_data   <= rd_data;
                    col_num    <= col + 1'b1;
                    if (is_final_col(col)) begin
                        active <= 1'b0;
                    end else begin
                        col <= col + 1'b1;
                    end
                end else begin
                    timer <= timer + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/card_feed_ctrl.sv
module card_feed_ctrl
    import card_feed_pkg::*;
#(
    parameter int CARD_SLOTS  = 4,
    parameter int FEED_CYCLES = 8,
    parameter int COL_GAP     = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_valid,
    input  logic [11:0] ld_data,
    output logic        ld_ready,
    output logic        hopper_empty,
    input  logic        feed_req,
    input  logic        lc_req,
    input  logic        runout,
    input  logic        stat_clr,
    output logic        col_strobe,
    output logic [11:0] col_data,
    output logic [6:0]  col_num,
    output logic        read_done,
    output logic [2:0]  dsw
);

    localparam int SLOT_W = $clog2(CARD_SLOTS);

    logic                 card_done;
    logic                 col_done;
    logic                 col_start;
    logic [SLOT_W-1:0]    rd_slot;
    logic [COL_IDX_W-1:0] rd_col;
    col_t                 rd_data;
    dsw_t                 status;
    logic                 wr_en;

    assign wr_en     = ld_valid && ld_ready;
    assign dsw       = status;
    assign read_done = col_done;

    card_feed_store #(
        .SLOTS(CARD_SLOTS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (ld_data),
        .card_done (card_done),
        .rd_slot   (rd_slot),
        .rd_col    (rd_col),
        .rd_data   (rd_data)
    );

    card_feed_seq #(
        .SLOTS       (CARD_SLOTS),
        .FEED_CYCLES (FEED_CYCLES)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .feed_req     (feed_req),
        .lc_req       (lc_req),
        .runout       (runout),
        .stat_clr     (stat_clr),
        .card_done    (card_done),
        .col_done     (col_done),
        .col_start    (col_start),
        .rd_slot      (rd_slot),
        .hopper_empty (hopper_empty),
        .ld_ready     (ld_ready),
        .status       (status)
    );

    card_feed_colout #(
        .COL_GAP(COL_GAP)
    ) u_col (
        .clk        (clk),
        .rst        (rst),
        .start      (col_start),
        .rd_data    (rd_data),
        .rd_col     (rd_col),
        .col_strobe (col_strobe),
        .col_data   (col_data),
        .col_num    (col_num),
        .done       (col_done)
    );

endmodule

// File: rtl/card_feed_ctrl_chk.sv
module card_feed_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ld_ready,
    input logic       hopper_empty,
    input logic       stat_clr,
    input logic       col_strobe,
    input logic [6:0] col_num,
    input logic       read_done,
    input logic [2:0] dsw
);

    AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        col_strobe |-> dsw[0]); // R4

    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        col_strobe |-> (col_num >= 7'd1) && (col_num <= 7'd80)); // R3

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        read_done |-> $past(col_strobe) && ($past(col_num) == 7'd80)); // R3

    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        read_done |=> !dsw[0] && !read_done); // R4

    AST_NOTREADY_EMPTY: assert property (@(posedge clk) disable iff (rst)
        dsw[1] |-> hopper_empty); // R5

    AST_FULL_NOT_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !ld_ready |-> !hopper_empty); // R1

    AST_LAST_HELD: assert property (@(posedge clk) disable iff (rst)
        (dsw[2] && !stat_clr) |=> dsw[2]); // R7

endmodule

bind card_feed_ctrl card_feed_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ld_ready     (ld_ready),
    .hopper_empty (hopper_empty),
    .stat_clr     (stat_clr),
    .col_strobe   (col_strobe),
    .col_num      (col_num),
    .read_done    (read_done),
    .dsw          (dsw)
);

// File: tb/card_feed_ctrl_test.sv
module card_feed_ctrl_test;

    localparam int F        = 8;
    localparam int G        = 2;
    localparam int COLS     = 80;
    localparam int READ_LEN = F + COLS * G + 2;

    localparam logic [2:0] OP_LOAD    = 3'd0;
    localparam logic [2:0] OP_FEED    = 3'd1;
    localparam logic [2:0] OP_HOLD    = 3'd2;
    localparam logic [2:0] OP_LOADRUN = 3'd3;
    localparam logic [2:0] OP_LAST    = 3'd4;
    localparam logic [2:0] OP_CLR     = 3'd5;
    localparam logic [2:0] OP_RUNOUT  = 3'd6;

    typedef struct packed {
        logic [2:0] op;
        logic [3:0] id;
        logic [3:0] exp_id;
        logic       exp_last;
    } step_t;

    localparam int NSTEPS = 23;
    localparam step_t STEPS [NSTEPS] = '{
        '{OP_LOAD,    4'd1, 4'd0, 1'b0},
        '{OP_LOAD,    4'd2, 4'd0, 1'b0},
        '{OP_LOAD,    4'd3, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd1, 1'b0},
        '{OP_FEED,    4'd0, 4'd2, 1'b0},
        '{OP_HOLD,    4'd0, 4'd0, 1'b0},
        '{OP_LOADRUN, 4'd4, 4'd3, 1'b0},
        '{OP_LAST,    4'd0, 4'd4, 1'b1},
        '{OP_CLR,     4'd0, 4'd0, 1'b0},
        '{OP_LOAD,    4'd5, 4'd0, 1'b0},
        '{OP_LOAD,    4'd6, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd0, 1'b0},
        '{OP_RUNOUT,  4'd0, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd0, 1'b0},
        '{OP_LOAD,    4'd7, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd6, 1'b0},
        '{OP_RUNOUT,  4'd0, 4'd0, 1'b0},
        '{OP_RUNOUT,  4'd0, 4'd0, 1'b0},
        '{OP_LOAD,    4'd8, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd0, 1'b0},
        '{OP_LOAD,    4'd9, 4'd0, 1'b0},
        '{OP_FEED,    4'd0, 4'd8, 1'b0}
    };

    logic        clk;
    logic        rst;
    logic        ld_valid;
    logic [11:0] ld_data;
    logic        ld_ready;
    logic        hopper_empty;
    logic        feed_req;
    logic        lc_req;
    logic        runout;
    logic        stat_clr;
    logic        col_strobe;
    logic [11:0] col_data;
    logic [6:0]  col_num;
    logic        read_done;
    logic [2:0]  dsw;

    int checks;
    int errors;
    int cyc;
    int last_cyc;
    int cap_id;
    int cap_cnt;
    int cap_bad;
    int gap_bad;
    int done_cnt;
    int done_bad;

    card_feed_ctrl #(
        .CARD_SLOTS  (4),
        .FEED_CYCLES (F),
        .COL_GAP     (G)
    ) uut (
        .clk          (clk),
        .rst          (rst),
        .ld_valid     (ld_valid),
        .ld_data      (ld_data),
        .ld_ready     (ld_ready),
        .hopper_empty (hopper_empty),
        .feed_req     (feed_req),
        .lc_req       (lc_req),
        .runout       (runout),
        .stat_clr     (stat_clr),
        .col_strobe   (col_strobe),
        .col_data     (col_data),
        .col_num      (col_num),
        .read_done    (read_done),
        .dsw          (dsw)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [11:0] pat(input int id, input int num);
        return {id[3:0], num[7:0]};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (col_strobe) begin
            if (cap_cnt > 0 && (cyc - last_cyc) != G) gap_bad++;
            last_cyc = cyc;
            if (col_num != 7'(cap_cnt + 1) || col_data != pat(cap_id, cap_cnt + 1)) cap_bad++;
            cap_cnt++;
        end
        if (read_done) begin
            done_cnt++;
            if (cap_cnt != COLS) done_bad++;
        end
    end

    task automatic clear_capture(input int id);
        cap_id   = id;
        cap_cnt  = 0;
        cap_bad  = 0;
        gap_bad  = 0;
        done_cnt = 0;
        done_bad = 0;
    endtask

    task automatic load_card(input int id);
        while (!ld_ready) @(negedge clk);
        for (int c = 1; c <= COLS; c++) begin
            ld_valid = 1'b1;
            ld_data  = pat(id, c);
            @(negedge clk);
        end
        ld_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_cycle(input int exp_id, input bit exp_last, input int bsy);
        if (exp_id != 0) begin
            chk("R2 strobes in read cycle", cap_cnt, COLS);
            chk("R3 column data and numbering", cap_bad, 0);
            chk("R3 strobe spacing", gap_bad, 0);
            chk("R4 busy length of read cycle", bsy, READ_LEN);
            chk("R4 read_done pulses", done_cnt, 1);
            chk("R4 read_done after column 80", done_bad, 0);
        end else begin
            chk("R2 strobes in feed-only cycle", cap_cnt, 0);
            chk("R4 busy length of feed-only cycle", bsy, F);
            chk("R4 no read_done in feed-only cycle", done_cnt, 0);
        end
        chk("R6 last-card bit after cycle", int'(dsw[2]), int'(exp_last));
    endtask

    task automatic wait_busy_low(output int bsy);
        bsy = 0;
        while (dsw[0]) begin
            bsy++;
            @(negedge clk);
        end
    endtask

    task automatic run_feed(input int exp_id, input bit exp_last);
        int bsy;
        clear_capture(exp_id);
        @(negedge clk);
        feed_req = 1'b1;
        @(negedge clk);
        feed_req = 1'b0;
        wait_busy_low(bsy);
        check_cycle(exp_id, exp_last, bsy);
    endtask

    task automatic pulse_lc();
        @(negedge clk);
        lc_req = 1'b1;
        @(negedge clk);
        lc_req = 1'b0;
    endtask

    task automatic pulse_runout();
        @(negedge clk);
        runout = 1'b1;
        @(negedge clk);
        runout = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int bsy;
        int busy_seen;
        int strobes_seen;
        checks   = 0;
        errors   = 0;
        cyc      = 0;
        last_cyc = 0;
        clear_capture(0);
        rst      = 1'b1;
        ld_valid = 1'b0;
        ld_data  = '0;
        feed_req = 1'b0;
        lc_req   = 1'b0;
        runout   = 1'b0;
        stat_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk("R10 status word after reset", int'(dsw), 2);
        chk("R10 hopper_empty after reset", int'(hopper_empty), 1);
        chk("R10 ld_ready after reset", int'(ld_ready), 1);
        chk("R10 no strobe after reset", int'(col_strobe), 0);

        for (int i = 0; i < NSTEPS; i++) begin
            step_t s;
            s = STEPS[i];
            case (s.op)
                OP_LOAD: begin
                    load_card(int'(s.id));
                    chk("R1 hopper holds a card after load", int'(hopper_empty), 0);
                end
                OP_FEED: run_feed(int'(s.exp_id), s.exp_last);
                OP_HOLD: begin
                    clear_capture(0);
                    @(negedge clk);
                    feed_req = 1'b1;
                    @(negedge clk);
                    feed_req = 1'b0;
                    busy_seen = 0;
                    for (int k = 0; k < 20; k++) begin
                        if (dsw[0]) busy_seen++;
                        @(negedge clk);
                    end
                    chk("R5 held request does not start a cycle", busy_seen, 0);
                    chk("R5 no strobes while held", cap_cnt, 0);
                    chk("R5 not-ready bit while held", int'(dsw[1]), 1);
                end
                OP_LOADRUN: begin
                    clear_capture(int'(s.exp_id));
                    load_card(int'(s.id));
                    while (!dsw[0]) @(negedge clk);
                    wait_busy_low(bsy);
                    check_cycle(int'(s.exp_id), s.exp_last, bsy);
                end
                OP_LAST: begin
                    pulse_lc();
                    chk("R6 armed last card clears not-ready", int'(dsw[1]), 0);
                    run_feed(int'(s.exp_id), s.exp_last);
                end
                OP_CLR: begin
                    repeat (10) @(negedge clk);
                    chk("R7 last-card bit held", int'(dsw[2]), 1);
                    @(negedge clk);
                    stat_clr = 1'b1;
                    @(negedge clk);
                    stat_clr = 1'b0;
                    chk("R7 last-card bit cleared by stat_clr", int'(dsw[2]), 0);
                end
                OP_RUNOUT: begin
                    clear_capture(0);
                    pulse_runout();
                    repeat (5) @(negedge clk);
                    chk("R8 runout issues no strobes", cap_cnt, 0);
                    chk("R8 runout does not start a cycle", int'(dsw[0]), 0);
                end
                default: ;
            endcase
        end

        // R6 arming used up: card 9 parked, hopper empty, so not ready again
        chk("R6 arming consumed after one cycle", int'(dsw[1]), 1);

        // R9 feed and runout during a cycle are ignored
        load_card(10);
        clear_capture(9);
        @(negedge clk);
        feed_req = 1'b1;
        @(negedge clk);
        feed_req = 1'b0;
        repeat (5) @(negedge clk);
        feed_req = 1'b1;
        runout   = 1'b1;
        @(negedge clk);
        feed_req = 1'b0;
        runout   = 1'b0;
        wait_busy_low(bsy);
        chk("R9 cycle still reads card 9", cap_cnt, COLS);
        chk("R9 card 9 data intact", cap_bad, 0);
        busy_seen    = 0;
        strobes_seen = cap_cnt;
        for (int k = 0; k < 20; k++) begin
            if (dsw[0]) busy_seen++;
            @(negedge clk);
        end
        chk("R9 feed during cycle not remembered", busy_seen, 0);
        chk("R9 no extra strobes", cap_cnt, strobes_seen);
        load_card(11);
        run_feed(10, 1'b0); // R9 runout during cycle did not discard card 10

        // R1 full store back-pressure
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 status word after second reset", int'(dsw), 2);
        for (int id = 11; id <= 14; id++) load_card(id);
        chk("R1 ld_ready low when all slots full", int'(ld_ready), 0);
        chk("R1 hopper not empty when full", int'(hopper_empty), 0);
        run_feed(0, 1'b0);
        chk("R1 still full after feed-only cycle", int'(ld_ready), 0);
        run_feed(11, 1'b0);
        chk("R1 slot freed after read", int'(ld_ready), 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule